// File: doc/BRIEF.md
# Floating-Point Exception Trap Arbiter

This block sits beside a floating-point arithmetic unit. Each time an instruction finishes, it records the exception flags that the instruction produced in a status exception byte. It then decides whether a trap is due and, when several exception classes qualify, which single class is reported and at which vector. Software can write the status exception byte and the enable byte directly. Neither kind of write can start a trap. Only flags that an instruction has just produced, checked against the enable byte, can raise a trap request. Four classes (SNAN, OPERR, OVFL, UNFL) also accept a nonmaskable condition that forces a trap while the class is disabled.

Both bytes use the same class order, bit 7 down to bit 0: BSUN, SNAN, OPERR, OVFL, UNFL, DZ, INEX2, INEX1. Bit 7 has the highest priority. The enable byte is the upper byte, bits 15 to 8, of the control register. Its bit 7 here is control-register bit 15.

Top module: `fp_trap_arbiter`

## Requirements
- R1: After reset, the status exception byte, the enable byte, trap_req, trap_class and trap_vec are all zero.
- R2: On a cycle with `done` high and no status write, the next cycle shows status bits 7..1 equal to `exc_flags[7:1]`. Earlier contents of those bits are discarded, not accumulated.
- R3: Status bit 0 (INEX1) is never changed by an instruction. `exc_flags[0]` is ignored, and bit 0 keeps its last software-written value.
- R4: A status write (`sts_we`) loads all eight bits from `sts_wdata` on the next cycle. It takes precedence over an instruction load in the same cycle.
- R5: An enable write (`ctl_we`) loads the enable byte from `ctl_wdata` on the next cycle. Bit 7 to bit 0 correspond to control-register bits 15 to 8.
- R6: `trap_req` is high for exactly the cycle after a `done` cycle, and only if some flag in `exc_flags[7:1]` is enabled in the enable byte as it stood during that `done` cycle. An enable write in the same cycle affects only later instructions.
- R7: A software write to either byte never raises `trap_req`. This holds even when it sets a status bit that is enabled, or enables a class whose status bit is already pending.
- R8: `nm_cond[3:0]` (bit 3 SNAN, bit 2 OPERR, bit 1 OVFL, bit 0 UNFL) makes its class trap while disabled, provided the same instruction raised that class's flag. A nonmaskable bit without the flag has no effect.
- R9: `trap_class` gives the bit index (7 = BSUN … 0 = INEX1) of the highest-priority qualifying class. Lower qualifying classes are never reported.
- R10: `trap_vec` is VEC_BASE plus a per-class offset: BSUN 0, INEX2/INEX1 1, DZ 2, UNFL 3, OPERR 4, OVFL 5, SNAN 6. The class and vector hold their values until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done | input | 1 | Instruction-complete strobe |
| exc_flags | input | 8 | Exception flags of the completing instruction, class order |
| nm_cond | input | 4 | Nonmaskable condition per class: SNAN, OPERR, OVFL, UNFL |
| sts_we | input | 1 | Software write strobe for the status exception byte |
| sts_wdata | input | 8 | Status exception byte write data |
| ctl_we | input | 1 | Software write strobe for the enable byte |
| ctl_wdata | input | 8 | Enable byte write data (control bits 15..8) |
| exc_byte | output | 8 | Status exception byte |
| en_byte | output | 8 | Enable byte |
| trap_req | output | 1 | One-cycle trap request |
| trap_class | output | 3 | Bit index of the reported class |
| trap_vec | output | VEC_W | Vector number of the reported class |

## Verification
The hardest cases to reach from the ports are the collisions between a completing instruction and software writes in the same cycle. In these cases the status byte must take the software value while the trap still follows the hardware flags and the old enable byte. The bench weights its random write strobes so that such collisions occur often, and a reference model tracks both bytes across them. Directed sequences add further cases: a fully enabled status write with no instruction, a late enable of a pending flag, and nonmaskable conditions on disabled classes with and without their flags.

// File: rtl/fp_trap_arbiter.sv
module fp_trap_arbiter #(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [7:0]       exc_flags,
  input  logic [3:0]       nm_cond,
  input  logic             sts_we,
  input  logic [7:0]       sts_wdata,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       exc_byte,
  output logic [7:0]       en_byte,
  output logic             trap_req,
  output logic [2:0]       trap_class,
  output logic [VEC_W-1:0] trap_vec
);

  localparam logic [7:0] HW_SET_MASK = 8'hFE;

  logic [7:0] raised, nm_vec, cand;
  logic [2:0] win;
  logic       fire;

  assign raised = exc_flags & HW_SET_MASK;
  assign nm_vec = {1'b0, nm_cond, 3'b000};
  assign cand   = raised & (en_byte | nm_vec);
  assign fire   = done && (cand != 8'h00);

  always_comb begin
    win = 3'd0;
    for (int i = 0; i < 8; i++)
      if (cand[i]) win = 3'(i);
  end

  function automatic logic [2:0] vec_off(input logic [2:0] cls);
    case (cls)
      3'd7:    vec_off = 3'd0;
      3'd6:    vec_off = 3'd6;
      3'd5:    vec_off = 3'd4;
      3'd4:    vec_off = 3'd5;
      3'd3:    vec_off = 3'd3;
      3'd2:    vec_off = 3'd2;
      default: vec_off = 3'd1;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_byte   <= '0;
      en_byte    <= '0;
      trap_req   <= 1'b0;
      trap_class <= '0;
      trap_vec   <= '0;
    end else begin
      if (sts_we)    exc_byte <= sts_wdata;
      else if (done) exc_byte <= {raised[7:1], exc_byte[0]};
      if (ctl_we)    en_byte  <= ctl_wdata;
      trap_req <= fire;
      if (fire) begin
        trap_class <= win;
        trap_vec   <= VEC_W'(VEC_BASE) + VEC_W'(vec_off(win));
      end
    end
  end

  // R6 / R7: a request only ever follows an instruction-complete cycle
  p_only_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> !trap_req);

  // R3: INEX1 moves only through a software write
  p_inex1_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sts_we) |-> exc_byte[0] == $past(exc_byte[0]));

  // R5: enable byte changes only on a write
  p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_we) |-> $stable(en_byte));

  // R9: the reported class is among the flags recorded
  p_winner_recorded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !$past(sts_we)) |-> exc_byte[trap_class]);

  // R8: a disabled class can win only through a nonmaskable condition
  p_disabled_is_nm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ((($past(en_byte) >> trap_class) & 8'h01) != 8'h00)
                 || (trap_class inside {3'd3, 3'd4, 3'd5, 3'd6}));

  // R10: class and vector hold between traps
  p_report_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> ($stable(trap_class) && $stable(trap_vec)));

endmodule

// File: tb/fp_trap_arbiter_bench.sv
`timescale 1ns/1ps
module fp_trap_arbiter_bench;
  localparam int VEC_W = 8;
  localparam int VEC_BASE = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic done = 1'b0, sts_we = 1'b0, ctl_we = 1'b0;
  logic [7:0] exc_flags = '0, sts_wdata = '0, ctl_wdata = '0;
  logic [3:0] nm_cond = '0;
  logic [7:0] exc_byte, en_byte;
  logic trap_req;
  logic [2:0] trap_class;
  logic [VEC_W-1:0] trap_vec;

  int errors = 0, checks = 0;
  logic [7:0] m_exc = '0, m_en = '0;
  logic m_req = 1'b0;
  logic [2:0] m_cls = '0;
  logic [VEC_W-1:0] m_vec = '0;

  always #4 clk = ~clk;

  fp_trap_arbiter #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_fp_trap_arbiter (
    .clk, .rst_n, .done, .exc_flags, .nm_cond, .sts_we, .sts_wdata,
    .ctl_we, .ctl_wdata, .exc_byte, .en_byte, .trap_req, .trap_class, .trap_vec);

  function automatic logic [2:0] top_bit(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic logic [VEC_W-1:0] exp_vec(input logic [2:0] c);
    int off;
    case (c)
      3'd7: off = 0; 3'd6: off = 6; 3'd5: off = 4; 3'd4: off = 5;
      3'd3: off = 3; 3'd2: off = 2; default: off = 1;
    endcase
    return VEC_W'(VEC_BASE + off);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic dn, input logic [7:0] fl, input logic [3:0] nm,
                       input logic swe, input logic [7:0] swd,
                       input logic cwe, input logic [7:0] cwd);
    logic [7:0] raised, cand;
    done = dn; exc_flags = fl; nm_cond = nm;
    sts_we = swe; sts_wdata = swd; ctl_we = cwe; ctl_wdata = cwd;
    raised = fl & 8'hFE;
    cand = raised & (m_en | {1'b0, nm, 3'b000});
    if (swe) m_exc = swd;
    else if (dn) m_exc = {raised[7:1], m_exc[0]};
    if (cwe) m_en = cwd;
    m_req = dn && (cand != 0);
    if (m_req) begin m_cls = top_bit(cand); m_vec = exp_vec(m_cls); end
    @(negedge clk);
    chk(exc_byte[7:1] == m_exc[7:1], swe ? "R4" : "R2", exc_byte, m_exc);
    chk(exc_byte[0] == m_exc[0], swe ? "R4" : "R3", exc_byte[0], m_exc[0]);
    chk(en_byte == m_en, "R5", en_byte, m_en);
    chk(trap_req == m_req, "R6", trap_req, m_req);
    chk(trap_class == m_cls, "R9", trap_class, m_cls);
    chk(trap_vec == m_vec, "R10", trap_vec, m_vec);
  endtask

  task automatic idle();
    cycle(1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] fl;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk(exc_byte == 0 && en_byte == 0, "R1", exc_byte, 0);
    chk(trap_req == 0 && trap_class == 0 && trap_vec == 0, "R1", trap_vec, 0);
    rst_n = 1'b1;

    // R7: fully enabled status write, then enabling a pending class
    cycle(1'b0, 8'h00, 4'h0, 1'b1, 8'hFF, 1'b0, 8'h00);
    cycle(1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 1'b1, 8'hFF);
    idle();
    chk(trap_req == 0, "R7", trap_req, 0);
    // R3: instruction with only INEX1 leaves the latched bit set
    cycle(1'b1, 8'h01, 4'h0, 1'b0, 8'h00, 1'b0, 8'h00);
    chk(exc_byte == 8'h01, "R3", exc_byte, 8'h01);
    // R9: OPERR and INEX2 both enabled, OPERR reported
    cycle(1'b1, 8'h22, 4'h0, 1'b0, 8'h00, 1'b0, 8'h00);
    chk(trap_class == 3'd5 && trap_vec == 8'd52, "R9", trap_vec, 52);
    idle();
    // R6: same-cycle enable write does not count for this instruction
    cycle(1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 1'b1, 8'h00);
    cycle(1'b1, 8'h04, 4'h0, 1'b0, 8'h00, 1'b1, 8'hFF);
    chk(trap_req == 0, "R6", trap_req, 0);
    cycle(1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 1'b1, 8'h00);
    // R8: nonmaskable OVFL on a disabled class traps
    cycle(1'b1, 8'h12, 4'h2, 1'b0, 8'h00, 1'b0, 8'h00);
    chk(trap_req == 1 && trap_class == 3'd4, "R8", trap_class, 4);
    // R8: nonmaskable conditions without their flags do nothing
    cycle(1'b1, 8'h04, 4'hF, 1'b0, 8'h00, 1'b0, 8'h00);
    chk(trap_req == 0, "R8", trap_req, 0);
    // R4: status write wins against an instruction load
    cycle(1'b1, 8'h40, 4'h0, 1'b1, 8'h81, 1'b0, 8'h00);
    chk(exc_byte == 8'h81, "R4", exc_byte, 8'h81);

    for (int n = 0; n < 3000; n++) begin
      case ($urandom_range(0, 8))
        0: fl = 8'h80;
        1: fl = 8'h40 | 8'($urandom_range(0, 1));
        2: fl = 8'h20 | 8'($urandom_range(0, 3));
        3: fl = 8'h10 | 8'($urandom_range(0, 3));
        4: fl = 8'h08 | 8'($urandom_range(0, 3));
        5: fl = 8'h04;
        6: fl = 8'h02;
        7: fl = 8'h00;
        default: fl = 8'($urandom);
      endcase
      cycle($urandom_range(0, 1) == 1, fl,
            ($urandom_range(0, 9) < 3) ? 4'($urandom) : 4'h0,
            $urandom_range(0, 9) == 0, 8'($urandom),
            $urandom_range(0, 6) == 0, 8'($urandom));
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule